// File: doc/BRIEF.md
# Write-Allocate Four-Way Cache Controller

This block is a write-back data cache controller that sits between a processor load/store port and a main-memory port that moves whole lines. An access compares its address tag against all four ways of the indexed set in parallel. A read hit returns the word in the same cycle. A store hit patches the word in the hitting way and marks the line dirty.

On a miss the controller allocates a way. If the set still has an empty way, it takes the lowest-numbered one. Otherwise it uses the way named on a separate victim-select input. A dirty victim is first written back to memory as a whole line. The missing line is then fetched as a whole line. In a final update cycle a store merges its word into the line and a load returns its word. Every transfer with memory is therefore a full line.

Tag, data, valid and dirty state live in one single-ported register bank per way. Each bank has its own write enable, decoded from the selected way number. A flush request clears every valid and dirty bit at once.

Top module: `wa_cache_ctrl`

## Requirements
- R1: After reset every line is invalid: `cpu_ready` is 1 with no request, `mem_req` is 0, and the first access to any address goes to memory.
- R2: A load whose tag matches a valid way of the set raises `cpu_ready` in the same cycle, without any memory request. `cpu_rdata` is word `cpu_addr[3:2]` of that line. Word k of a line occupies bits [32k+31:32k] of the line buses.
- R3: A store hit writes `cpu_wdata` into the addressed word of the hitting way and marks that line dirty, with no memory traffic. The line is later written back on eviction.
- R4: On a miss `cpu_ready` stays 0 until the fill has finished. The victim is the lowest-numbered invalid way of the set when one exists, otherwise the way given by `victim_way`.
- R5: A dirty victim is written back first, with `mem_we`=1, `mem_addr` = {victim tag, set index, 4'b0000} and `mem_wline` = the victim's whole line.
- R6: A victim that is invalid or clean is not written back. The controller requests the fill directly.
- R7: The fill uses `mem_we`=0 and `mem_addr` = the request's line address (low four bits zero). The fetched line is installed with the new tag. A load miss returns its word from the fetched line in the completion cycle. A store miss merges its word into the line and leaves it valid and dirty.
- R8: `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`. The fill request starts only after the write-back has been acknowledged.
- R9: A flush request raised while the controller is idle clears all valid and dirty bits at the next edge. Dirty data is discarded without a write-back, and `cpu_ready` is 0 in the flush cycle.
- R10: At most one way bank is written in any cycle, and a write to one way leaves the lines of the other ways of the set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is 1 |
| cpu_ready | output | 1 | Access completes at this edge |
| victim_way | input | 2 | Way to replace when the set has no empty way |
| flush_req | input | 1 | Invalidate all lines |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wline | output | 128 | Line written back |
| mem_rline | input | 128 | Line returned by a fill |
| mem_ack | input | 1 | Memory completes the transfer at this edge |

## Verification
The bench builds the controller with its default parameters: four ways, sixteen sets, four-word lines and 32-bit words. It limits stimulus to eight tags, so a 128-line memory model covers every address in use. With eight tags against four ways, every set can be filled, hit on every word, dirtied and then forced through dirty and clean evictions with every victim number.

The memory side answers after zero to two wait cycles. This exposes the hold-until-acknowledge behaviour and the write-back-then-fill order. A flush followed by reloads shows that dirty data is discarded.

// File: rtl/cache_pkg.sv
// Shared definitions for the write-allocate cache controller.
// Assumes: the controller has exactly four sequencing states.
package cache_pkg;

    // Controller states: idle lookup, dirty write-back, line fetch, final merge/return
    typedef enum logic [1:0] {
        ST_LOOKUP    = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_FILL      = 2'd2,
        ST_UPDATE    = 2'd3
    } ctrl_state_t;

endpackage

// File: rtl/cache_way_bank.sv
// One way of the cache: tag, line data, valid and dirty storage for every set.
// Single ported: one index per cycle serves both the combinational read and
// at most one write (whole-line install or single-word patch).
// Assumes: line_we and word_we are never raised together.
module cache_way_bank #(
    parameter int SETS   = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 24,
    parameter int WORD_W = 32,
    parameter int WSEL_W = 2,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic [IDX_W-1:0]  idx,
    input  logic              line_we,
    input  logic              word_we,
    input  logic [WSEL_W-1:0] word_sel,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [WORD_W-1:0] wr_word,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    output logic              rd_valid,
    output logic              rd_dirty
);

    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;

    // State bits: cleared by reset or flush, set by install or store patch
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (line_we) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (word_we) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Payload storage: whole-line install with tag, or one-word patch
    always_ff @(posedge clk) begin
        if (line_we) begin
            tag_q[idx]  <= wr_tag;
            line_q[idx] <= wr_line;
        end else if (word_we) begin
            line_q[idx][word_sel*WORD_W +: WORD_W] <= wr_word;
        end
    end

    // Read side of the single port
    assign rd_tag   = tag_q[idx];
    assign rd_line  = line_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

    // R3
    dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0);

    // R10
    single_port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_we && word_we));

endmodule

// File: rtl/cache_way_decode.sv
// Turns a way number plus an enable into one write strobe per way bank.
// Assumes: sel is below WAYS.
module cache_way_decode #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic             en,
    input  logic [WAY_W-1:0] sel,
    output logic [WAYS-1:0]  strobe
);

    // One comparator per way bank
    for (genvar g = 0; g < WAYS; g++) begin : g_dec
        assign strobe[g] = en && (sel == WAY_W'(g));
    end

endmodule

// File: rtl/cache_victim_pick.sv
// Chooses the way to replace: the lowest-numbered empty way of the set,
// otherwise the externally supplied way number.
// Assumes: fallback is below WAYS.
module cache_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAY_W-1:0] fallback,
    output logic [WAY_W-1:0] victim
);

    // Priority scan from way 0 upward for an empty slot
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = fallback;
        for (int i = 0; i < WAYS; i++) begin
            if (!valid_vec[i] && !found) begin
                victim = WAY_W'(i);
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wa_cache_ctrl.sv
// Write-back, write-allocate set-associative cache controller.
// Looks up all ways of a set in parallel. On a miss it writes back a dirty
// victim, fetches the whole line, then merges a store word or returns a load
// word in an update cycle. Memory transfers are always whole lines.
// Assumes: cpu_req and its address/data stay stable until cpu_ready; the memory
// side holds mem_rline valid in the cycle it raises mem_ack.
module wa_cache_ctrl #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int SETS   = 16,
    parameter int WAYS   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [WORD_W-1:0]       cpu_wdata,
    output logic [WORD_W-1:0]       cpu_rdata,
    output logic                    cpu_ready,
    input  logic [$clog2(WAYS)-1:0] victim_way,
    input  logic                    flush_req,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORDS*WORD_W-1:0] mem_wline,
    input  logic [WORDS*WORD_W-1:0] mem_rline,
    input  logic                    mem_ack
);
    import cache_pkg::*;

    localparam int BOFF_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int LOW_W  = WSEL_W + BOFF_W;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - LOW_W;
    localparam int LINE_W = WORDS * WORD_W;
    localparam int WAY_W  = $clog2(WAYS);

    ctrl_state_t       state_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              pend_we_q;
    logic [WORD_W-1:0] pend_wdata_q;
    logic [WAY_W-1:0]  pend_way_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag;
    logic [IDX_W-1:0]  cur_idx;
    logic [WSEL_W-1:0] cur_wsel;

    logic [TAG_W-1:0]  way_tag   [WAYS];
    logic [LINE_W-1:0] way_line  [WAYS];
    logic [WAYS-1:0]   way_valid;
    logic [WAYS-1:0]   way_dirty;
    logic [WAYS-1:0]   hit_vec;
    logic [WAYS-1:0]   fill_strobe;
    logic [WAYS-1:0]   word_strobe;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim_sel;
    logic [LINE_W-1:0] hit_line;
    logic              hit;
    logic              lookup_go;
    logic              store_commit;
    logic              fill_commit;
    logic              clear_all;

    // Address in use: live request while idle, latched request during a miss
    always_comb begin
        cur_addr = (state_q == ST_LOOKUP) ? cpu_addr : pend_addr_q;
        cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
        cur_idx  = cur_addr[LOW_W +: IDX_W];
        cur_wsel = cur_addr[BOFF_W +: WSEL_W];
    end

    // Per-way storage banks, all receiving the same write data and tag
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        cache_way_bank #(
            .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W),
            .WORD_W(WORD_W), .WSEL_W(WSEL_W), .LINE_W(LINE_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_all(clear_all),
            .idx      (cur_idx),
            .line_we  (fill_strobe[g]),
            .word_we  (word_strobe[g]),
            .word_sel (cur_wsel),
            .wr_tag   (cur_tag),
            .wr_line  (mem_rline),
            .wr_word  ((state_q == ST_LOOKUP) ? cpu_wdata : pend_wdata_q),
            .rd_tag   (way_tag[g]),
            .rd_line  (way_line[g]),
            .rd_valid (way_valid[g]),
            .rd_dirty (way_dirty[g])
        );
        assign hit_vec[g] = way_valid[g] && (way_tag[g] == cur_tag);
    end

    // Encode the matching way and select the addressed word
    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
        hit       = |hit_vec;
        hit_line  = way_line[hit_way];
        cpu_rdata = hit_line[cur_wsel*WORD_W +: WORD_W];
    end

    cache_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid_vec(way_valid),
        .fallback (victim_way),
        .victim   (victim_sel)
    );

    // Control strobes for this cycle
    always_comb begin
        lookup_go    = (state_q == ST_LOOKUP) && !flush_req && cpu_req;
        store_commit = (lookup_go && cpu_we && hit) || ((state_q == ST_UPDATE) && pend_we_q);
        fill_commit  = (state_q == ST_FILL) && mem_ack;
        clear_all    = (state_q == ST_LOOKUP) && flush_req;
        cpu_ready    = ((state_q == ST_LOOKUP) && !flush_req && (!cpu_req || hit))
                     || (state_q == ST_UPDATE);
    end

    cache_way_decode #(.WAYS(WAYS), .WAY_W(WAY_W)) u_fill_dec (
        .en(fill_commit), .sel(pend_way_q), .strobe(fill_strobe)
    );

    cache_way_decode #(.WAYS(WAYS), .WAY_W(WAY_W)) u_word_dec (
        .en(store_commit), .sel(hit_way), .strobe(word_strobe)
    );

    // Memory port: write-back of the victim, or fetch of the missing line
    always_comb begin
        mem_req   = (state_q == ST_WRITEBACK) || (state_q == ST_FILL);
        mem_we    = (state_q == ST_WRITEBACK);
        mem_wline = way_line[pend_way_q];
        if (state_q == ST_WRITEBACK)
            mem_addr = {way_tag[pend_way_q], cur_idx, {LOW_W{1'b0}}};
        else
            mem_addr = {cur_tag, cur_idx, {LOW_W{1'b0}}};
    end

    // Sequencer: lookup, optional write-back, fill, update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOOKUP;
        end else begin
            case (state_q)
                ST_LOOKUP:
                    if (lookup_go && !hit)
                        state_q <= (way_valid[victim_sel] && way_dirty[victim_sel])
                                   ? ST_WRITEBACK : ST_FILL;
                ST_WRITEBACK: if (mem_ack) state_q <= ST_FILL;
                ST_FILL:      if (mem_ack) state_q <= ST_UPDATE;
                default:      state_q <= ST_LOOKUP;
            endcase
        end
    end

    // Capture the missing request and its victim at miss detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr_q  <= '0;
            pend_we_q    <= 1'b0;
            pend_wdata_q <= '0;
            pend_way_q   <= '0;
        end else if (lookup_go && !hit) begin
            pend_addr_q  <= cpu_addr;
            pend_we_q    <= cpu_we;
            pend_wdata_q <= cpu_wdata;
            pend_way_q   <= victim_sel;
        end
    end

    // R4
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITEBACK || state_q == ST_FILL) |-> !cpu_ready);

    // R4
    empty_way_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_go && !hit && !(&way_valid)) |-> !way_valid[victim_sel]);

    // R3
    store_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_go && cpu_we && hit) |=> !mem_req);

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R8
    wb_before_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITEBACK && !mem_ack) |=> (state_q == ST_WRITEBACK));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (way_valid == '0 && way_dirty == '0));

    // R10
    one_way_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_strobe, word_strobe}));

endmodule

// File: tb/wa_cache_ctrl_bench.sv
// Self-checking bench: reference model of tags, valid/dirty state and line
// contents plus a 128-line memory model. Stimulus uses eight tags per set.
module wa_cache_ctrl_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0, flush_req = 1'b0, mem_ack = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0, cpu_rdata, mem_addr;
    logic [1:0]   victim_way = '0;
    logic         cpu_ready, mem_req, mem_we;
    logic [127:0] mem_wline, mem_rline = '0;

    always #5 clk = ~clk;

    wa_cache_ctrl u_wa_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .victim_way(victim_way), .flush_req(flush_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack)
    );

    int tests = 0, fails = 0, fills = 0, delay_ctr = 0;
    logic [31:0] mem     [128][4];
    bit          m_valid [16][4];
    bit          m_dirty [16][4];
    int          m_tag   [16][4];
    logic [31:0] m_data  [16][4][4];

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkaddr(int tag, int idx, int w);
        return 32'((tag << 8) | (idx << 4) | (w << 2));
    endfunction

    // One processor access, serving the memory side and checking every cycle
    task automatic access(input bit we, input int tag, input int idx, input int w,
                          input logic [31:0] wdata, input int vic, input string hit_req);
        int h = -1, v = -1, cyc = 0, seen = 0, dly = 0;
        bit exp_wb = 0, wb_done = 0, fill_done = 0, done = 0;
        logic [127:0] exp_line;
        for (int i = 0; i < 4; i++)
            if (m_valid[idx][i] && m_tag[idx][i] == tag) h = i;
        if (h < 0) begin
            for (int i = 0; i < 4; i++)
                if (!m_valid[idx][i] && v < 0) v = i;
            if (v < 0) v = vic;
            exp_wb = m_valid[idx][v] && m_dirty[idx][v];
        end
        cpu_req = 1'b1; cpu_we = we; cpu_addr = mkaddr(tag, idx, w);
        cpu_wdata = wdata; victim_way = 2'(vic);
        dly = delay_ctr % 3; delay_ctr++;
        while (!done && cyc < 60) begin
            #1;
            if (cpu_ready) begin
                if (h >= 0) begin
                    check(cyc == 0, "R2", 128'(cyc), 128'd0);
                    if (!we) check(cpu_rdata == m_data[idx][h][w], hit_req,
                                   128'(cpu_rdata), 128'(m_data[idx][h][w]));
                    else begin m_data[idx][h][w] = wdata; m_dirty[idx][h] = 1; end
                end else begin
                    check(fill_done && wb_done == exp_wb, "R4", 128'({fill_done, wb_done}),
                          128'({1'b1, exp_wb}));
                    if (!we) check(cpu_rdata == mem[tag*16+idx][w], "R7",
                                   128'(cpu_rdata), 128'(mem[tag*16+idx][w]));
                    m_valid[idx][v] = 1; m_tag[idx][v] = tag; m_dirty[idx][v] = we;
                    for (int k = 0; k < 4; k++) m_data[idx][v][k] = mem[tag*16+idx][k];
                    if (we) m_data[idx][v][w] = wdata;
                end
                done = 1;
            end else if (mem_req) begin
                if (h >= 0) begin
                    check(0, "R2", 128'(mem_addr), 128'd0);
                    mem_ack = 1'b1;
                end else if (mem_we) begin
                    check(exp_wb && !wb_done, "R6", 128'(mem_we), 128'd0);
                    if (exp_wb && !wb_done) begin
                        check(mem_addr == mkaddr(m_tag[idx][v], idx, 0), "R5",
                              128'(mem_addr), 128'(mkaddr(m_tag[idx][v], idx, 0)));
                        exp_line = {m_data[idx][v][3], m_data[idx][v][2],
                                    m_data[idx][v][1], m_data[idx][v][0]};
                        check(mem_wline == exp_line, "R5", mem_wline, exp_line);
                    end
                    if (seen == dly) begin
                        if (exp_wb && !wb_done)
                            for (int k = 0; k < 4; k++)
                                mem[m_tag[idx][v]*16+idx][k] = mem_wline[k*32 +: 32];
                        mem_ack = 1'b1; wb_done = 1; seen = 0;
                    end else seen++;
                end else begin
                    // R8: fill only after any write-back was acknowledged
                    check(!exp_wb || wb_done, "R8", 128'(wb_done), 128'd1);
                    check(mem_addr == mkaddr(tag, idx, 0), "R7",
                          128'(mem_addr), 128'(mkaddr(tag, idx, 0)));
                    if (seen == dly) begin
                        for (int k = 0; k < 4; k++) mem_rline[k*32 +: 32] = mem[tag*16+idx][k];
                        mem_ack = 1'b1; fill_done = 1; fills++; seen = 0;
                    end else seen++;
                end
            end
            @(posedge clk); @(negedge clk);
            mem_ack = 1'b0; cyc++;
        end
        if (!done) check(0, "R4", 128'(cyc), 128'd0);
        cpu_req = 1'b0;
    endtask

    task automatic do_flush();
        flush_req = 1'b1;
        #1;
        check(!cpu_ready && !mem_req, "R9", 128'({cpu_ready, mem_req}), 128'd0);
        @(posedge clk); @(negedge clk);
        flush_req = 1'b0;
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 4; i++) begin m_valid[s][i] = 0; m_dirty[s][i] = 0; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int f0;
        for (int l = 0; l < 128; l++)
            for (int k = 0; k < 4; k++) mem[l][k] = 32'(32'hC0DE0000 + l * 16 + k);
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 4; i++) begin m_valid[s][i] = 0; m_dirty[s][i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(cpu_ready && !mem_req, "R1", 128'({cpu_ready, mem_req}), 128'd2);
        f0 = fills;
        access(0, 0, 0, 0, '0, 3, "R2");
        check(fills == f0 + 1, "R1", 128'(fills - f0), 128'd1);

        // Fill every way of every set from empty (lowest empty way first)
        for (int s = 0; s < 16; s++)
            for (int t = 0; t < 4; t++) access(0, t, s, t, '0, 3, "R4");
        // Read every word of every resident line
        for (int s = 0; s < 16; s++)
            for (int t = 0; t < 4; t++)
                for (int w = 0; w < 4; w++) access(0, t, s, w, '0, 0, "R2");
        // Store hits, then confirm neighbours untouched
        for (int s = 0; s < 16; s++)
            for (int t = 0; t < 4; t++)
                access(1, t, s, (t + s) % 4, 32'h5000_0000 | 32'(s << 8) | 32'(t), 0, "R3");
        for (int s = 0; s < 16; s++)
            for (int t = 0; t < 4; t++)
                for (int w = 0; w < 4; w++) access(0, t, s, w, '0, 0, "R10");
        // Store misses evicting dirty lines
        for (int s = 0; s < 16; s++)
            for (int t = 4; t < 8; t++)
                access(1, t, s, t % 4, 32'h7700_0000 | 32'(s << 8) | 32'(t), (s + t) % 4, "R3");
        // Mixed loads: clean and dirty victims of every way number
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 8; t++) access(0, t, s, s, '0, (t * 3 + s) % 4, "R2");
        // Flush discards dirty lines; reloads come from memory
        do_flush();
        for (int s = 0; s < 16; s++)
            for (int t = 4; t < 8; t++) access(0, t, s, t % 4, '0, t % 4, "R9");
        for (int s = 0; s < 16; s++) access(1, 2, s, 1, 32'hABCD_0000 | 32'(s), 1, "R7");
        for (int s = 0; s < 16; s++) access(0, 2, s, 1, '0, 1, "R7");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule